// File: doc/BRIEF.md
# Four-Slot Hit Derandomizer with Shared Ramp Converter

This block is the digital control for one detector channel. It watches a discriminator output and stamps each hit with the value of a free-running coarse time counter. Four storage slots are handed out in turn, so that new hits can be taken in while a slow conversion of an earlier hit is still running.

A mode input, sampled at the rising edge of each hit, chooses between two kinds of capture. In duration mode the falling edge is also stamped, and the charge is reported as the pulse length. In amplitude mode only the rising edge is stamped. The held peak is then measured by a counter that runs until an external ramp comparator trips.

Finished slots leave the block in arrival order as one event word per hit, on a valid/ready handshake. A slot is reused only after its word has been accepted. Hits that find every slot taken are counted and discarded. A pulse that stays high too long is closed after a programmable number of cycles.

Top module: `hit_derandomizer`

## Requirements
- R1: Accepted hits are placed in slots 0, 1, 2, 3, 0, ... in turn, and each event word reports its slot index on `evSlot`.
- R2: With `modeAmp`=0 at the rising edge, the hit records `tsIn` at the first cycle `discIn` is high and at the first cycle it is low again. The event has `evMode`=0 and `evValue` equal to the second stamp minus the first, modulo 2^TS_W.
- R3: With `modeAmp`=1 at the rising edge, only the rising stamp is recorded and the falling edge of that hit has no effect. The event has `evMode`=1 and `evValue` equal to the converter count in the cycle where `rampCross` is sampled high.
- R4: A conversion starts with its count at 0 in its first active cycle and adds one per cycle while `convBusy` is high. If the count reaches 1023 without a crossing, the event carries 1023 with `evOvf`=1. Otherwise `evOvf`=0.
- R5: Events are emitted in the order their hits arrived. A slot is released only when its event word is accepted (`evValid` and `evReady` both high at a clock edge).
- R6: A rising edge that arrives while all four slots are in use is dropped, and `lostCount` increases by one, saturating at its maximum.
- R7: A falling edge with no duration-mode hit open (after a drop, after a timeout, or in amplitude mode) changes no slot and no output.
- R8: In duration mode, if `discIn` stays high for `stuckLimit` cycles after the rising-edge cycle, the hit is closed with `evValue`=1023 and `evOvf`=1.
- R9: While `evValid` is high and `evReady` is low, `evValid` and every event field hold steady.
- R10: A synchronous `rst` empties all slots and clears the lost counter, the converter and the output within one clock edge.
- R11: A duration above 1023 cycles is reported as 1023 with `evOvf`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| discIn | input | 1 | Discriminator output, synchronous to clk |
| modeAmp | input | 1 | 1 = amplitude capture, 0 = duration capture; sampled at the rising edge |
| tsIn | input | TS_W | Coarse timestamp counter |
| stuckLimit | input | TMO_W | Cycles a duration hit may stay high before forced closure |
| rampCross | input | 1 | Ramp comparator crossing |
| convBusy | output | 1 | Converter counting; the external ramp should run |
| evValid | output | 1 | Event word valid |
| evReady | input | 1 | Event word accepted |
| evSlot | output | 2 | Slot index of the event |
| evMode | output | 1 | Capture mode of the event (1 = amplitude) |
| evRise | output | TS_W | Rising-edge timestamp |
| evValue | output | VAL_W | Duration or amplitude value |
| evOvf | output | 1 | Value saturated |
| lostCount | output | LOST_W | Number of dropped hits |

## Verification
Every result has a fixed latency:
- Lost count: changes at the clock edge that samples the rejected rising edge.
- Duration hit: its event becomes valid one edge after the edge that samples the falling edge or the timeout.
- Amplitude hit: the edge after the rising edge starts the converter. The count is 0 at the next edge and crossing at count c yields a valid event after edge k+2+c, where k is the rising-edge edge.

The bench keeps a behavioural queue model that is stepped on each rising clock edge with the same sampled inputs. All outputs are compared against it at every falling edge, so any cycle of slip shows up as a miscompare. The ramp comparator is driven from the model's own count, which makes every crossing land on a known cycle.

// File: rtl/hit_derand_pkg.sv
package hit_derand_pkg;
  localparam int NSLOT = 4;
  localparam int IDX_W = $clog2(NSLOT);

  typedef enum logic [1:0] {CV_IDLE, CV_RUN, CV_OUT} conv_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             capRise;
    logic             capFall;
    logic             capTmo;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
    logic             convClr;
    logic             convInc;
    logic             outLoad;
    logic             outFromConv;
    logic             outSat;
    logic             lostInc;
  } strobe_t;
endpackage

// File: rtl/hit_derand_ctrl.sv
module hit_derand_ctrl
  import hit_derand_pkg::*;
#(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             discIn,
  input  logic             modeAmp,
  input  logic             rampCross,
  input  logic             convFull,
  input  logic             evReady,
  input  logic [TMO_W-1:0] stuckLimit,
  output strobe_t          stb,
  output logic             convBusy,
  output logic             evValid
);
  localparam logic [IDX_W:0] FULL = (IDX_W+1)'(NSLOT);

  logic             discPrev, openHit, riseEdge, fallEdge, freeSlot;
  logic [IDX_W-1:0] wrPtr, rdPtr, openIdx;
  logic [IDX_W:0]   used;
  logic [NSLOT-1:0] filled, slotAmp;
  logic [TMO_W-1:0] openCnt;
  conv_state_e      st, nxtSt;

  always_comb begin
    stb         = '0;
    nxtSt       = st;
    freeSlot    = 1'b0;
    riseEdge    = discIn & ~discPrev;
    fallEdge    = ~discIn & discPrev;
    stb.capRise = riseEdge && (used != FULL);
    stb.lostInc = riseEdge && (used == FULL);
    stb.capFall = openHit && fallEdge;
    stb.capTmo  = openHit && !fallEdge && (openCnt == stuckLimit - TMO_W'(1));
    stb.wrIdx   = stb.capRise ? wrPtr : openIdx;
    stb.rdIdx   = rdPtr;
    unique case (st)
      CV_IDLE: if (filled[rdPtr]) begin
        if (slotAmp[rdPtr]) begin
          stb.convClr = 1'b1;
          nxtSt       = CV_RUN;
        end else begin
          stb.outLoad = 1'b1;
          nxtSt       = CV_OUT;
        end
      end
      CV_RUN: if (rampCross) begin
        stb.outLoad     = 1'b1;
        stb.outFromConv = 1'b1;
        nxtSt           = CV_OUT;
      end else if (convFull) begin
        stb.outLoad     = 1'b1;
        stb.outFromConv = 1'b1;
        stb.outSat      = 1'b1;
        nxtSt           = CV_OUT;
      end else begin
        stb.convInc = 1'b1;
      end
      CV_OUT: if (evReady) begin
        freeSlot = 1'b1;
        nxtSt    = CV_IDLE;
      end
      default: nxtSt = CV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      discPrev <= 1'b0;
      openHit  <= 1'b0;
      openIdx  <= '0;
      openCnt  <= '0;
      wrPtr    <= '0;
      rdPtr    <= '0;
      used     <= '0;
      filled   <= '0;
      slotAmp  <= '0;
      st       <= CV_IDLE;
    end else begin
      discPrev <= discIn;
      st       <= nxtSt;
      used     <= used + (IDX_W+1)'(stb.capRise) - (IDX_W+1)'(freeSlot);
      if (stb.capRise) begin
        wrPtr          <= wrPtr + 1'b1;
        slotAmp[wrPtr] <= modeAmp;
        openIdx        <= wrPtr;
        openCnt        <= '0;
        if (modeAmp) filled[wrPtr] <= 1'b1;
        else         openHit       <= 1'b1;
      end
      if (stb.capFall || stb.capTmo) begin
        openHit         <= 1'b0;
        filled[openIdx] <= 1'b1;
      end else if (openHit) begin
        openCnt <= openCnt + 1'b1;
      end
      if (freeSlot) begin
        filled[rdPtr] <= 1'b0;
        rdPtr         <= rdPtr + 1'b1;
      end
    end
  end

  assign convBusy = (st == CV_RUN);
  assign evValid  = (st == CV_OUT);

  a_r5_occupancy_bound: assert property (@(posedge clk) disable iff (rst)
    used <= FULL);
  a_r9_valid_hold: assert property (@(posedge clk) disable iff (rst)
    evValid && !evReady |=> evValid);
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (used == '0) && !evValid && !convBusy);
endmodule

// File: rtl/hit_derand_dp.sv
module hit_derand_dp
  import hit_derand_pkg::*;
#(
  parameter int TS_W   = 12,
  parameter int VAL_W  = 10,
  parameter int LOST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [TS_W-1:0]   tsIn,
  input  logic              evValid,
  input  logic              evReady,
  output logic              convFull,
  output logic [IDX_W-1:0]  evSlot,
  output logic              evMode,
  output logic [TS_W-1:0]   evRise,
  output logic [VAL_W-1:0]  evValue,
  output logic              evOvf,
  output logic [LOST_W-1:0] lostCount
);
  localparam logic [VAL_W-1:0]  VAL_MAX  = '1;
  localparam logic [LOST_W-1:0] LOST_MAX = '1;

  logic [TS_W-1:0]  riseTs [NSLOT];
  logic [VAL_W-1:0] totVal [NSLOT];
  logic [NSLOT-1:0] totOvf;
  logic [VAL_W-1:0] convCnt;
  logic [TS_W-1:0]  span;
  logic [VAL_W-1:0] spanVal;
  logic             spanSat;

  assign span = tsIn - riseTs[stb.wrIdx];

  generate
    if (TS_W > VAL_W) begin : g_sat
      assign spanSat = |span[TS_W-1:VAL_W];
      assign spanVal = spanSat ? VAL_MAX : span[VAL_W-1:0];
    end else begin : g_nosat
      assign spanSat = 1'b0;
      assign spanVal = VAL_W'(span);
    end
  endgenerate

  assign convFull = (convCnt == VAL_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) begin
        riseTs[i] <= '0;
        totVal[i] <= '0;
      end
      totOvf    <= '0;
      convCnt   <= '0;
      lostCount <= '0;
      evSlot    <= '0;
      evMode    <= 1'b0;
      evRise    <= '0;
      evValue   <= '0;
      evOvf     <= 1'b0;
    end else begin
      if (stb.capRise) riseTs[stb.wrIdx] <= tsIn;
      if (stb.capFall) begin
        totVal[stb.wrIdx] <= spanVal;
        totOvf[stb.wrIdx] <= spanSat;
      end else if (stb.capTmo) begin
        totVal[stb.wrIdx] <= VAL_MAX;
        totOvf[stb.wrIdx] <= 1'b1;
      end
      if (stb.convClr)      convCnt <= '0;
      else if (stb.convInc) convCnt <= convCnt + 1'b1;
      if (stb.lostInc && lostCount != LOST_MAX) lostCount <= lostCount + 1'b1;
      if (stb.outLoad) begin
        evSlot  <= stb.rdIdx;
        evMode  <= stb.outFromConv;
        evRise  <= riseTs[stb.rdIdx];
        evValue <= stb.outFromConv ? convCnt : totVal[stb.rdIdx];
        evOvf   <= stb.outFromConv ? stb.outSat : totOvf[stb.rdIdx];
      end
    end
  end

  a_r9_fields_stable: assert property (@(posedge clk) disable iff (rst)
    evValid && !evReady |=> $stable(evValue) && $stable(evSlot) &&
                            $stable(evRise) && $stable(evOvf) && $stable(evMode));
  a_r4_no_count_past_full: assert property (@(posedge clk) disable iff (rst)
    convFull |-> !stb.convInc);
  a_r2_close_not_with_open: assert property (@(posedge clk) disable iff (rst)
    (stb.capFall || stb.capTmo) |-> !stb.capRise);
endmodule

// File: rtl/hit_derandomizer.sv
module hit_derandomizer
  import hit_derand_pkg::*;
#(
  parameter int TS_W   = 12,
  parameter int VAL_W  = 10,
  parameter int LOST_W = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              discIn,
  input  logic              modeAmp,
  input  logic [TS_W-1:0]   tsIn,
  input  logic [TMO_W-1:0]  stuckLimit,
  input  logic              rampCross,
  output logic              convBusy,
  output logic              evValid,
  input  logic              evReady,
  output logic [1:0]        evSlot,
  output logic              evMode,
  output logic [TS_W-1:0]   evRise,
  output logic [VAL_W-1:0]  evValue,
  output logic              evOvf,
  output logic [LOST_W-1:0] lostCount
);
  strobe_t stb;
  logic    convFull;

  hit_derand_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rst(rst), .discIn(discIn), .modeAmp(modeAmp),
    .rampCross(rampCross), .convFull(convFull), .evReady(evReady),
    .stuckLimit(stuckLimit), .stb(stb), .convBusy(convBusy), .evValid(evValid)
  );

  hit_derand_dp #(.TS_W(TS_W), .VAL_W(VAL_W), .LOST_W(LOST_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .tsIn(tsIn), .evValid(evValid),
    .evReady(evReady), .convFull(convFull), .evSlot(evSlot), .evMode(evMode),
    .evRise(evRise), .evValue(evValue), .evOvf(evOvf), .lostCount(lostCount)
  );
endmodule

// File: tb/sim_hit_derandomizer.sv
`timescale 1ns/1ps
module sim_hit_derandomizer;
  localparam int TS_W = 12, VAL_W = 10, LOST_W = 8, TMO_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, discIn, modeAmp, rampCross, evReady;
  logic [TS_W-1:0] tsIn;
  logic [TMO_W-1:0] stuckLimit;
  logic convBusy, evValid, evMode, evOvf;
  logic [1:0] evSlot;
  logic [TS_W-1:0] evRise;
  logic [VAL_W-1:0] evValue;
  logic [LOST_W-1:0] lostCount;

  hit_derandomizer #(.TS_W(TS_W), .VAL_W(VAL_W), .LOST_W(LOST_W), .TMO_W(TMO_W)) u0 (
    .clk(clk), .rst(rst), .discIn(discIn), .modeAmp(modeAmp), .tsIn(tsIn),
    .stuckLimit(stuckLimit), .rampCross(rampCross), .convBusy(convBusy),
    .evValid(evValid), .evReady(evReady), .evSlot(evSlot), .evMode(evMode),
    .evRise(evRise), .evValue(evValue), .evOvf(evOvf), .lostCount(lostCount)
  );

  typedef struct {
    int slot; bit amp; int rise; int val; bit ovf; bit done; int tgt;
  } ent_t;

  ent_t q[$];
  bit mPrev = 0, mOpen = 0;
  int mOpenCnt = 0, mWr = 0, mSt = 0, mCnt = 0, mLost = 0;
  int mOutSlot = 0, mOutRise = 0, mOutVal = 0;
  bit mOutMode = 0, mOutOvf = 0;
  int vecs = 0, miss = 0, cyc = 0, tgtNext = 0;
  bit finished = 0;
  string curReq = "R10";

  // behavioural reference, stepped on each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      q.delete(); mPrev = 0; mOpen = 0; mOpenCnt = 0; mWr = 0; mSt = 0;
      mCnt = 0; mLost = 0; mOutSlot = 0; mOutRise = 0; mOutVal = 0;
      mOutMode = 0; mOutOvf = 0;
    end else begin
      int usedPre;
      bit rise, fall, free;
      usedPre = q.size();
      rise = discIn && !mPrev;
      fall = !discIn && mPrev;
      free = 0;
      case (mSt)
        0: if (usedPre > 0 && q[0].done) begin
          if (q[0].amp) begin mSt = 1; mCnt = 0; end
          else begin
            mOutSlot = q[0].slot; mOutMode = 0; mOutRise = q[0].rise;
            mOutVal = q[0].val; mOutOvf = q[0].ovf; mSt = 2;
          end
        end
        1: if (rampCross || mCnt == 1023) begin
          mOutSlot = q[0].slot; mOutMode = 1; mOutRise = q[0].rise;
          mOutVal = mCnt; mOutOvf = !rampCross; mSt = 2;
        end else mCnt++;
        default: if (evReady) begin free = 1; mSt = 0; end
      endcase
      if (rise) begin
        if (usedPre == 4) begin
          if (mLost < 255) mLost++;
        end else begin
          ent_t e;
          e.slot = mWr; e.amp = modeAmp; e.rise = int'(tsIn); e.val = 0;
          e.ovf = 0; e.done = modeAmp; e.tgt = tgtNext;
          q.push_back(e);
          mWr = (mWr + 1) % 4;
          if (!modeAmp) begin mOpen = 1; mOpenCnt = 0; end
        end
      end else if (mOpen) begin
        if (fall) begin
          int d;
          d = (int'(tsIn) - q[$].rise + 4096) % 4096;
          q[$].val = (d > 1023) ? 1023 : d;
          q[$].ovf = (d > 1023);
          q[$].done = 1; mOpen = 0;
        end else if (mOpenCnt == (int'(stuckLimit) + 65535) % 65536) begin
          q[$].val = 1023; q[$].ovf = 1; q[$].done = 1; mOpen = 0;
        end else mOpenCnt++;
      end
      if (free) void'(q.pop_front());
      mPrev = discIn;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
  endtask

  // compare and drive the comparator away from the active edge
  always @(negedge clk) begin
    if (!finished) begin
      chk("evValid", int'(evValid), int'(mSt == 2));
      chk("convBusy", int'(convBusy), int'(mSt == 1));
      chk("lostCount", int'(lostCount), mLost);
      if (mSt == 2) begin
        chk("evSlot", int'(evSlot), mOutSlot);
        chk("evMode", int'(evMode), int'(mOutMode));
        chk("evRise", int'(evRise), mOutRise);
        chk("evValue", int'(evValue), mOutVal);
        chk("evOvf", int'(evOvf), int'(mOutOvf));
      end
      rampCross = (mSt == 1) && (q.size() > 0) && (mCnt == q[0].tgt);
      tsIn = tsIn + 1'b1;
      if (cyc > 150000) begin
        miss++;
        $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
        finished = 1;
        summary();
        $finish;
      end
    end
  end

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hit(input bit amp, input int width, input int tgt);
    @(negedge clk);
    modeAmp = amp; tgtNext = tgt; discIn = 1'b1;
    repeat (width) @(negedge clk);
    discIn = 1'b0;
  endtask

  initial begin
    rst = 1'b1; discIn = 1'b0; modeAmp = 1'b0; rampCross = 1'b0;
    evReady = 1'b1; tsIn = '0; stuckLimit = 16'd500;
    gap(3);
    rst = 1'b0;
    gap(3);
    curReq = "R2";           // duration hits of different widths
    hit(0, 5, 0);   gap(20);
    hit(0, 9, 0);   gap(20);
    curReq = "R3";           // amplitude hits; their falling edges are ignored
    hit(1, 3, 37);  gap(60);
    hit(1, 12, 0);  gap(20);
    curReq = "R4";           // no crossing: count saturates at 1023
    hit(1, 4, 5000); gap(1100);
    curReq = "R1 R6";        // stall output: four slots fill, two hits lost
    evReady = 1'b0;
    for (int i = 0; i < 6; i++) begin hit(i % 2, 3, 10 + i); gap(4); end
    gap(10);
    curReq = "R5 R9";        // drain in order with an irregular ready
    for (int i = 0; i < 60; i++) begin evReady = (i % 3 == 0); gap(1); end
    evReady = 1'b1;
    gap(80);
    curReq = "R8 R7";        // stuck-high pulse closed by timeout, late fall ignored
    stuckLimit = 16'd20;
    hit(0, 50, 0);  gap(20);
    curReq = "R11";          // duration longer than the value range
    stuckLimit = 16'd3000;
    hit(0, 1100, 0); gap(20);
    curReq = "R10";          // reset with slots occupied
    evReady = 1'b0;
    hit(0, 4, 0); gap(2);
    hit(1, 4, 900); gap(2);
    hit(0, 4, 0); gap(5);
    rst = 1'b1; gap(1); rst = 1'b0;
    evReady = 1'b1;
    gap(20);
    curReq = "R3";           // normal operation after reset
    hit(1, 2, 3); gap(20);
    finished = 1;
    summary();
    $finish;
  end
endmodule